// File: doc/BRIEF.md
# Four-State Switch Debouncer

This block cleans up one mechanical switch. The raw contact first passes through a short synchroniser chain. After that, a four-state machine holds what it believes about the switch. There are two stable states, open and closed, and two transitional states, closing and opening.

When the synchronised input disagrees with the believed level, the machine enters the matching transitional state and starts a settle counter. It takes no notice of the contact until the counter runs out. It then looks at the input once. If the input is at the new level, the machine commits to it. If the input has gone back to the old level, the machine returns to the old stable state and the disturbance counts as noise.

The block drives a debounced level and two one-cycle event pulses, one for press and one for release. Each edge has its own parameter that sets when its event fires:

- **Immediate:** the event fires as soon as the change is first seen.
- **Confirmed:** the event fires only once the settle period has confirmed the change.

The two parameters can differ, which gives an asymmetric policy, for example a fast press with a careful release.

Top module: `switch_debouncer`

## Requirements
- R1: During and right after reset the block is in the stable open state, `level_out` is 0, and neither event pulse is asserted. On `sw_raw`, 1 means closed (pressed) and 0 means open.
- R2: `sw_raw` passes through `SYNC_STAGES` flops (default 2) before the state machine sees it. A level applied ahead of rising edge k therefore causes a state change at edge k+2.
- R3: In a stable state, a synchronised input that differs from `level_out` moves the machine to the matching transitional state and starts the settle counter. Closed input from open leads to closing; open input from closed leads to opening.
- R4: In a transitional state the input is ignored for `SETTLE_CYCLES` clock cycles. `level_out` does not change before the `SETTLE_CYCLES`-th edge after the transitional state was entered, whatever the input does meanwhile.
- R5: At expiry, if the synchronised input is back at the old level, the machine returns to the old stable state and `level_out` keeps its value.
- R6: At expiry, if the synchronised input is at the new level, the machine enters the other stable state. `level_out` takes the new value on the `SETTLE_CYCLES`-th edge after the transitional state was entered.
- R7: With `PRESS_IMMEDIATE`=1, `press_pulse` fires on the edge that enters closing. With `PRESS_IMMEDIATE`=0, it fires on the edge where `level_out` rises.
- R8: With `RELEASE_IMMEDIATE`=1, `release_pulse` fires on the edge that enters opening. With `RELEASE_IMMEDIATE`=0, it fires on the edge where `level_out` falls.
- R9: Each event pulse lasts exactly one cycle. The two pulses are never high in the same cycle.
- R10: An immediate event whose change is later judged to be noise is not withdrawn, and no opposite event is emitted for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_raw | input | 1 | Raw switch contact, 1 = closed |
| level_out | output | 1 | Debounced switch level, 1 = closed |
| press_pulse | output | 1 | One-cycle press event |
| release_pulse | output | 1 | One-cycle release event |

## Verification
The assertions check the following on every cycle:

- The pulses are exclusive and last one cycle.
- A transitional state holds until the counter expires.
- `level_out` changes only when leaving a transitional state.
- A noise timeout returns to the old stable state.
- Each pulse occurs in the state or at the level edge that its policy demands.

Only the bench scenarios can show the exact cycle counts: the synchroniser latency, the length of the settle window, and when each event fires relative to the input edge. The same holds for bounces being ignored inside the window, and for no counter-event following a noise case under either policy.

// File: rtl/debounce_pkg.sv
package debounce_pkg;
    typedef enum logic [1:0] {
        ST_OPEN    = 2'd0,
        ST_CLOSED  = 2'd1,
        ST_OPENING = 2'd2,
        ST_CLOSING = 2'd3
    } sw_state_e;

    typedef struct packed {
        sw_state_e state;
        logic      level;
        logic      press;
        logic      rel;
    } fsm_regs_t;
endpackage

// File: rtl/sync_chain.sv
module sync_chain #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          run_d, run_q;

    assign expired = run_q && (cnt_q == '0);

    always_comb begin
        cnt_d = cnt_q;
        run_d = run_q;
        if (start) begin
            cnt_d = LOAD;
            run_d = 1'b1;
        end else if (expired) begin
            run_d = 1'b0;
        end else if (run_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/debounce_fsm.sv
module debounce_fsm
    import debounce_pkg::*;
#(
    parameter bit PRESS_IMMEDIATE   = 1'b1,
    parameter bit RELEASE_IMMEDIATE = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sw_sync,
    input  logic      expired,
    output logic      start,
    output sw_state_e state,
    output logic      level,
    output logic      press,
    output logic      rel
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.press = 1'b0;
        r_d.rel   = 1'b0;
        start     = 1'b0;
        case (r_q.state)
            ST_OPEN: begin
                if (sw_sync) begin
                    r_d.state = ST_CLOSING;
                    start     = 1'b1;
                    r_d.press = PRESS_IMMEDIATE;
                end
            end
            ST_CLOSED: begin
                if (!sw_sync) begin
                    r_d.state = ST_OPENING;
                    start     = 1'b1;
                    r_d.rel   = RELEASE_IMMEDIATE;
                end
            end
            ST_CLOSING: begin
                if (expired) begin
                    if (sw_sync) begin
                        r_d.state = ST_CLOSED;
                        r_d.level = 1'b1;
                        r_d.press = !PRESS_IMMEDIATE;
                    end else begin
                        r_d.state = ST_OPEN;
                    end
                end
            end
            ST_OPENING: begin
                if (expired) begin
                    if (!sw_sync) begin
                        r_d.state = ST_OPEN;
                        r_d.level = 1'b0;
                        r_d.rel   = !RELEASE_IMMEDIATE;
                    end else begin
                        r_d.state = ST_CLOSED;
                    end
                end
            end
            default: r_d.state = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_OPEN;
            r_q.level <= 1'b0;
            r_q.press <= 1'b0;
            r_q.rel   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state = r_q.state;
    assign level = r_q.level;
    assign press = r_q.press;
    assign rel   = r_q.rel;
endmodule

// File: rtl/switch_debouncer.sv
module switch_debouncer
    import debounce_pkg::*;
#(
    parameter int SETTLE_CYCLES     = 16,
    parameter int SYNC_STAGES       = 2,
    parameter bit PRESS_IMMEDIATE   = 1'b1,
    parameter bit RELEASE_IMMEDIATE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_raw,
    output logic level_out,
    output logic press_pulse,
    output logic release_pulse
);
    logic      sync_w;
    logic      expired_w;
    logic      start_w;
    sw_state_e state_w;

    sync_chain #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sw_raw),
        .dout (sync_w)
    );

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_w),
        .expired(expired_w)
    );

    debounce_fsm #(
        .PRESS_IMMEDIATE  (PRESS_IMMEDIATE),
        .RELEASE_IMMEDIATE(RELEASE_IMMEDIATE)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .sw_sync(sync_w),
        .expired(expired_w),
        .start  (start_w),
        .state  (state_w),
        .level  (level_out),
        .press  (press_pulse),
        .rel    (release_pulse)
    );
endmodule

// File: rtl/debounce_checks.sv
module debounce_checks
    import debounce_pkg::*;
#(
    parameter bit PRESS_IMMEDIATE   = 1'b1,
    parameter bit RELEASE_IMMEDIATE = 1'b0
) (
    input logic      clk,
    input logic      rst_n,
    input logic      sw_sync,
    input logic      expired,
    input sw_state_e state,
    input logic      level,
    input logic      press,
    input logic      rel
);
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(press && rel));

    a_r9_press_single: assert property (@(posedge clk) disable iff (!rst_n)
        press |=> !press);

    a_r9_release_single: assert property (@(posedge clk) disable iff (!rst_n)
        rel |=> !rel);

    a_r4_hold_closing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSING && !expired) |=> (state == ST_CLOSING));

    a_r4_hold_opening: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPENING && !expired) |=> (state == ST_OPENING));

    a_r6_level_from_transit: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(level) |-> ($past(state) == ST_CLOSING || $past(state) == ST_OPENING));

    a_r5_revert_closing: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLOSING && expired && !sw_sync) |=> (state == ST_OPEN && !level));

    a_r5_revert_opening: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPENING && expired && sw_sync) |=> (state == ST_CLOSED && level));

    generate
        if (PRESS_IMMEDIATE) begin : g_press_imm
            a_r7_press_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
                press |-> (state == ST_CLOSING));
        end else begin : g_press_conf
            a_r7_press_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
                press |-> $rose(level));
        end
        if (RELEASE_IMMEDIATE) begin : g_rel_imm
            a_r8_release_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
                rel |-> (state == ST_OPENING));
        end else begin : g_rel_conf
            a_r8_release_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
                rel |-> $fell(level));
        end
    endgenerate
endmodule

bind switch_debouncer debounce_checks #(
    .PRESS_IMMEDIATE  (PRESS_IMMEDIATE),
    .RELEASE_IMMEDIATE(RELEASE_IMMEDIATE)
) u_checks (
    .clk    (clk),
    .rst_n  (rst_n),
    .sw_sync(sync_w),
    .expired(expired_w),
    .state  (state_w),
    .level  (level_out),
    .press  (press_pulse),
    .rel    (release_pulse)
);

// File: tb/switch_debouncer_test.sv
module switch_debouncer_test;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int K_PRESS    = 0;
    localparam int K_REL      = 1;

    typedef struct {
        int cyc;
        int unit;
        int kind;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_raw = 1'b0;
    logic lvl0, prs0, rel0, lvl1, prs1, rel1;

    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // unit 0: immediate press, confirmed release
    switch_debouncer #(.SETTLE_CYCLES(N), .PRESS_IMMEDIATE(1'b1), .RELEASE_IMMEDIATE(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .sw_raw(sw_raw),
        .level_out(lvl0), .press_pulse(prs0), .release_pulse(rel0));

    // unit 1: confirmed press, immediate release
    switch_debouncer #(.SETTLE_CYCLES(N), .PRESS_IMMEDIATE(1'b0), .RELEASE_IMMEDIATE(1'b1)) uut_alt (
        .clk(clk), .rst_n(rst_n), .sw_raw(sw_raw),
        .level_out(lvl1), .press_pulse(prs1), .release_pulse(rel1));

    task automatic expect_evt(input int c, input int unit, input int kind);
        exp_t e;
        e.cyc = c; e.unit = unit; e.kind = kind;
        sb_q.push_back(e);
    endtask

    function automatic string tag(input int kind);
        return (kind == K_PRESS) ? "R7" : "R8";
    endfunction

    task automatic take(input int unit, input int kind);
        int idx = -1;
        for (int i = 0; i < sb_q.size(); i++)
            if (idx < 0 && sb_q[i].cyc == cyc && sb_q[i].unit == unit && sb_q[i].kind == kind)
                idx = i;
        checks++;
        if (idx >= 0) sb_q.delete(idx);
        else begin
            fails++;
            $display("FAIL %s/R10: unit %0d event %0d at cycle %0d, expected none then", tag(kind), unit, kind, cyc);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prs0 && rel0) begin
                checks++; fails++;
                $display("FAIL R9: unit 0 both pulses at cycle %0d, expected exclusive", cyc);
            end
            if (prs0) take(0, K_PRESS);
            if (rel0) take(0, K_REL);
            if (prs1) take(1, K_PRESS);
            if (rel1) take(1, K_REL);
            for (int i = 0; i < sb_q.size(); i++) begin
                if (sb_q[i].cyc < cyc) begin
                    checks++; fails++;
                    $display("FAIL %s: unit %0d missed event at cycle %0d (actual none, expected 1)",
                             tag(sb_q[i].kind), sb_q[i].unit, sb_q[i].cyc);
                    sb_q.delete(i);
                    break;
                end
            end
        end
    end

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drive(input logic v, output int p);
        @(negedge clk);
        sw_raw = v;
        p = cyc;
    endtask

    task automatic check_level(input string req, input logic e0, input logic e1);
        checks++;
        if (lvl0 !== e0 || lvl1 !== e1) begin
            fails++;
            $display("FAIL %s: cycle %0d level actual %b/%b expected %b/%b", req, cyc, lvl0, lvl1, e0, e1);
        end
    endtask

    initial begin
        int p, q;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_level("R1", 1'b0, 1'b0);
        checks++;
        if (prs0 || rel0 || prs1 || rel1) begin
            fails++;
            $display("FAIL R1: pulses actual %b%b%b%b expected 0000", prs0, rel0, prs1, rel1);
        end
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check_level("R1", 1'b0, 1'b0);

        // R2 R3 R6 R7: clean close
        drive(1'b1, p);
        expect_evt(p + 3, 0, K_PRESS);
        expect_evt(p + 3 + N, 1, K_PRESS);
        wait_until(p + 2 + N);
        check_level("R4", 1'b0, 1'b0);
        wait_until(p + 3 + N);
        check_level("R6", 1'b1, 1'b1);
        wait_until(p + 3 + N + 6);

        // R8 R6: clean open
        drive(1'b0, p);
        expect_evt(p + 3, 1, K_REL);
        expect_evt(p + 3 + N, 0, K_REL);
        wait_until(p + 2 + N);
        check_level("R4", 1'b1, 1'b1);
        wait_until(p + 3 + N);
        check_level("R6", 1'b0, 1'b0);
        wait_until(p + 3 + N + 6);

        // R5 R10: noise closure, immediate press not retracted, no release
        drive(1'b1, p);
        expect_evt(p + 3, 0, K_PRESS);
        wait_until(p + 2);
        @(negedge clk); sw_raw = 1'b0;
        wait_until(p + 3 + N + 2);
        check_level("R5", 1'b0, 1'b0);
        wait_until(p + 3 + N + 10);

        // R4: bouncing closure, bounces ignored, one event per policy
        drive(1'b1, p);
        expect_evt(p + 3, 0, K_PRESS);
        expect_evt(p + 3 + N, 1, K_PRESS);
        drive(1'b0, q);
        drive(1'b1, q);
        drive(1'b0, q);
        drive(1'b1, q);
        wait_until(p + 2 + N);
        check_level("R4", 1'b0, 1'b0);
        wait_until(p + 3 + N);
        check_level("R6", 1'b1, 1'b1);
        wait_until(p + 3 + N + 6);

        // R5 R10: noise opening, immediate release not retracted, no press
        drive(1'b0, p);
        expect_evt(p + 3, 1, K_REL);
        wait_until(p + 2);
        @(negedge clk); sw_raw = 1'b1;
        wait_until(p + 3 + N + 2);
        check_level("R5", 1'b1, 1'b1);
        wait_until(p + 3 + N + 10);

        // final open
        drive(1'b0, p);
        expect_evt(p + 3, 1, K_REL);
        expect_evt(p + 3 + N, 0, K_REL);
        wait_until(p + 3 + N);
        check_level("R6", 1'b0, 1'b0);
        wait_until(p + 3 + N + 6);

        checks++;
        if (sb_q.size() != 0) begin
            fails++;
            $display("FAIL R9: %0d events outstanding, expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule